// File: doc/BRIEF.md
# Pseudo-static RAM access sequencer

This block sits between an on-chip requester and an external asynchronous 16-bit pseudo-static RAM. The requester offers one access at a time over a valid/ready handshake: a 17-bit word address, a write flag, 16 bits of write data and a 2-bit lane select. The block turns that access into a chip-enable-controlled read or write on the memory pins. Read data comes back with a one-cycle valid pulse.

Every memory timing minimum is turned into a whole number of clock cycles. The conversion uses the clock period parameter and a speed-grade parameter that picks the 55 ns or the 70 ns timing set. When no access is in progress, the two chip enables are held at their deselected levels so the memory stays in standby. The bidirectional data bus is split into an output, an output enable and an input, and the block handles turnaround on that bus.

Top module: `psram_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready_o` is high, the memory is deselected: `mem_ce1_no`=1, `mem_ce2_o`=0, `mem_oe_no`=1, `mem_we_no`=1, and `mem_dq_oe_o`=0.
- R2: The address is placed on `mem_addr_o` at least one cycle before the chip enables go active. It stays unchanged for as long as the chip enables are active.
- R3: A read holds the chip enables active, `mem_oe_no` low and `mem_we_no` high for exactly RD cycles. The byte enables are driven low for the selected lanes, where lane bit 0 is bits 7:0 / `mem_lb_no` and lane bit 1 is bits 15:8 / `mem_ub_no`. OE and WE are never low together.
- R4: Read data is sampled at the clock edge that ends the last read cycle. It is presented with `rsp_valid_o` high for exactly one cycle. A lane that was not selected returns zero.
- R5: A write holds the chip enables active, `mem_we_no` low and the selected byte enables low for exactly WR cycles, and all of them end on the same edge.
- R6: A write of lane select 01 changes only bits 7:0 in memory, 10 changes only bits 15:8, and 11 changes the whole word. Lane select 00 runs a write cycle with both byte enables high and leaves the memory unchanged.
- R7: `mem_dq_oe_o` is high only while `mem_we_no` is low and `mem_oe_no` is high.
- R8: After `mem_oe_no` rises, `mem_dq_oe_o` stays low for at least HZ cycles, where HZ = ceil(25 ns / period).
- R9: Each count is rounded up to whole cycles, with a minimum of one. For the fast grade, RD = ceil(55 ns/T) and WR = max(ceil(50 ns/T), ceil(55 ns/T)-1). For the slow grade, RD = ceil(70 ns/T) and WR = max(ceil(55 ns/T), ceil(70 ns/T)-1). At a 4 ns period on the fast grade these give RD=14, WR=13 and HZ=7.
- R10: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. After that edge, `req_ready_o` stays low until the access has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request can be taken |
| req_addr_i | input | 17 | Word address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data |
| req_mask_i | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 16 | Read data |
| mem_addr_o | output | 17 | Memory address |
| mem_ce1_no | output | 1 | Chip enable, active low |
| mem_ce2_o | output | 1 | Chip enable, active high |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_lb_no | output | 1 | Low byte enable, active low |
| mem_ub_no | output | 1 | High byte enable, active low |
| mem_dq_o | output | 16 | Data bus, driven side |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus, received side |

## Verification
The bench runs directed accesses with each of the four lane selects, then reads the word back with every lane select. This separates a lane that was wrongly written from a lane that was wrongly returned. A read followed at once by a write exercises the shortest possible turnaround gap. A long random mix over a small pool of addresses builds up overlapping partial writes, so that the mixing of lanes and the address path are both checked against a reference image. The length of every strobe pulse is measured at the pins and compared with the cycle counts derived from the timing rules.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_READ, ST_WRITE} seq_e;

  function automatic int unsigned cyc_up(int unsigned ps, int unsigned clk_ps);
    int unsigned n;
    n = (ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // read: max of cycle time, CE access, OE access
  function automatic int unsigned rd_cycles(bit fast, int unsigned clk_ps);
    return fast ? cyc_up(max2(55000, max2(55000, 25000)), clk_ps)
                : cyc_up(max2(70000, max2(70000, 35000)), clk_ps);
  endfunction

  // write: widest of the to-write-end minimums; cycle time minus the setup cycle
  function automatic int unsigned wr_cycles(bit fast, int unsigned clk_ps);
    int unsigned pulse, cyc;
    pulse = fast ? cyc_up(max2(max2(45000, 40000), max2(50000, 25000)), clk_ps)
                 : cyc_up(max2(max2(55000, 55000), max2(55000, 25000)), clk_ps);
    cyc   = cyc_up(fast ? 55000 : 70000, clk_ps);
    cyc   = (cyc > 1) ? cyc - 1 : 1;
    return max2(pulse, cyc);
  endfunction

  function automatic int unsigned hz_cycles(int unsigned clk_ps);
    return cyc_up(25000, clk_ps);
  endfunction
endpackage

// File: rtl/psram_cnt.sv
module psram_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/psram_lanes.sv
module psram_lanes #(
  parameter int unsigned DW = 16,
  localparam int unsigned NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [NB-1:0] mask_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rdata_o[i*8 +: 8] <= '0;
      else if (cap_i)  rdata_o[i*8 +: 8] <= mask_i[i] ? dq_i[i*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int unsigned CLK_PS     = 4000,
  parameter bit          FAST_GRADE = 1'b1,
  parameter int unsigned AW         = 17,
  parameter int unsigned DW         = 16,
  localparam int unsigned NB        = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_we_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [NB-1:0] req_mask_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce1_no,
  output logic          mem_ce2_o,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic          mem_lb_no,
  output logic          mem_ub_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int unsigned RD_CYC = rd_cycles(FAST_GRADE, CLK_PS);
  localparam int unsigned WR_CYC = wr_cycles(FAST_GRADE, CLK_PS);
  localparam int unsigned HZ_CYC = hz_cycles(CLK_PS);
  localparam int unsigned CW     = $clog2(max2(RD_CYC, WR_CYC) + 1);
  localparam int unsigned GW     = $clog2(HZ_CYC + 1);

  seq_e          state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic [DW-1:0] wdata_q;
  logic [NB-1:0] mask_q;
  logic          acc_load, acc_done, gap_load, gap_done, cap, accept;
  logic [CW-1:0] acc_val;
  logic          ce_act_q, oe_act_q, we_act_q, dq_oe_q, rsp_q;
  logic [NB-1:0] be_n_q;

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    acc_load = 1'b0;
    acc_val  = '0;
    gap_load = 1'b0;
    cap      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        accept  = 1'b1;
        state_d = ST_SETUP;
      end
      ST_SETUP: if (!we_q) begin
        acc_load = 1'b1;
        acc_val  = CW'(RD_CYC - 1);
        state_d  = ST_READ;
      end else if (gap_done) begin
        acc_load = 1'b1;
        acc_val  = CW'(WR_CYC - 1);
        state_d  = ST_WRITE;
      end
      ST_READ: if (acc_done) begin
        cap      = 1'b1;
        gap_load = 1'b1;
        state_d  = ST_IDLE;
      end
      ST_WRITE: if (acc_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      mask_q   <= '0;
      ce_act_q <= 1'b0;
      oe_act_q <= 1'b0;
      we_act_q <= 1'b0;
      dq_oe_q  <= 1'b0;
      be_n_q   <= '1;
      rsp_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= req_addr_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
        mask_q  <= req_mask_i;
      end
      // pin strobes registered from the next state: glitch-free, aligned with state_q
      ce_act_q <= (state_d == ST_READ) || (state_d == ST_WRITE);
      oe_act_q <= (state_d == ST_READ);
      we_act_q <= (state_d == ST_WRITE);
      dq_oe_q  <= (state_d == ST_WRITE);
      be_n_q   <= ((state_d == ST_READ) || (state_d == ST_WRITE)) ? ~mask_q : '1;
      rsp_q    <= cap;
    end
  end

  psram_cnt #(.W(CW)) u_acc_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(acc_load), .val_i(acc_val), .done_o(acc_done)
  );

  psram_cnt #(.W(GW)) u_gap_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(gap_load), .val_i(GW'(HZ_CYC - 1)),
    .done_o(gap_done)
  );

  psram_lanes #(.DW(DW)) u_lanes (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap), .mask_i(mask_q),
    .dq_i(mem_dq_i), .rdata_o(rsp_rdata_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = rsp_q;
  assign mem_addr_o  = addr_q;
  assign mem_ce1_no  = ~ce_act_q;
  assign mem_ce2_o   = ce_act_q;
  assign mem_oe_no   = ~oe_act_q;
  assign mem_we_no   = ~we_act_q;
  assign mem_lb_no   = be_n_q[0];
  assign mem_ub_no   = be_n_q[NB-1];
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = dq_oe_q;

  AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce1_no && !mem_ce2_o && mem_oe_no && mem_we_no && !mem_dq_oe_o)); // R1
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce1_no |-> $stable(mem_addr_o)); // R2
  AST_NO_OE_WE_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no)); // R3
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R4
  AST_DQ_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_we_no && mem_oe_no)); // R7
  AST_TURNAROUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> gap_done); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R10
endmodule

// File: tb/sim_psram_ctrl.sv
`timescale 1ns/1ps
module sim_psram_ctrl;
  localparam int unsigned CLK_PS = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        ce1_n, ce2, oe_n, we_n, lb_n, ub_n, dq_oe;
  logic [15:0] dq_out;
  logic [15:0] dq_in = '0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] mem_m [int unsigned];
  logic [15:0] exp_m [int unsigned];
  logic [16:0] pool [8];

  always #2 clk = ~clk;

  psram_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_wdata_i(req_wdata), .req_mask_i(req_mask),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .mem_addr_o(mem_addr),
    .mem_ce1_no(ce1_n), .mem_ce2_o(ce2), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_lb_no(lb_n), .mem_ub_no(ub_n), .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe),
    .mem_dq_i(dq_in)
  );

  function automatic int unsigned up(int unsigned ps);
    int unsigned n = (ps + CLK_PS - 1) / CLK_PS;
    return (n < 1) ? 1 : n;
  endfunction
  function automatic int unsigned exp_rd();
    return up(55000);
  endfunction
  function automatic int unsigned exp_wr();
    int unsigned a = up(50000);
    int unsigned b = up(55000) - 1;
    return (a > b) ? a : b;
  endfunction
  function automatic int unsigned exp_hz();
    return up(25000);
  endfunction
  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] d, logic [1:0] m);
    return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
  endfunction
  function automatic logic [15:0] exp_word(logic [16:0] a);
    return exp_m.exists(a) ? exp_m[a] : 16'h0;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // memory model and pin monitors
  logic [16:0] cur_addr;
  logic [1:0]  cur_mask;
  bit          prev_sel = 1'b0;
  bit          prev_dq_oe = 1'b0;
  int          rd_run = 0, wr_run = 0, gap_run = 1000;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] v;
      bit sel;
      sel = !ce1_n && ce2;
      if (sel && !oe_n && we_n) begin
        v = mem_m.exists(mem_addr) ? mem_m[mem_addr] : 16'h0;
        dq_in <= {ub_n ? 8'h00 : v[15:8], lb_n ? 8'h00 : v[7:0]};
      end else dq_in <= 16'h0;
      if (sel && !we_n && dq_oe) begin
        v = mem_m.exists(mem_addr) ? mem_m[mem_addr] : 16'h0;
        mem_m[mem_addr] = merge(v, dq_out, {~ub_n, ~lb_n});
      end
      if (sel && !prev_sel) begin
        chk(mem_addr == cur_addr, "R2 addr at select", mem_addr, cur_addr);
        chk({ub_n, lb_n} == ~cur_mask, "R3/R5 byte enables", {ub_n, lb_n}, ~cur_mask);
      end
      if (dq_oe != prev_dq_oe || dq_oe)
        chk(!dq_oe || (!we_n && oe_n), "R7 drive window", {we_n, oe_n}, 2'b01);
      if (!oe_n) rd_run++;
      else if (rd_run > 0) begin
        chk(rd_run == exp_rd(), "R3/R9 read strobe cycles", rd_run, exp_rd());
        rd_run = 0;
      end
      if (!we_n) wr_run++;
      else if (wr_run > 0) begin
        chk(wr_run == exp_wr(), "R5/R9 write strobe cycles", wr_run, exp_wr());
        chk(ce1_n && !ce2 && ub_n && lb_n, "R5 common end", {ce1_n, ce2, ub_n, lb_n}, 4'b1011);
        wr_run = 0;
      end
      if (!oe_n) gap_run = 0;
      else if (dq_oe && !prev_dq_oe)
        chk(gap_run >= exp_hz(), "R8 turnaround gap", gap_run, exp_hz());
      else if (!dq_oe && gap_run < 1000) gap_run++;
      prev_sel   = sel;
      prev_dq_oe = dq_oe;
    end
  end

  task automatic issue(bit we, logic [16:0] a, logic [15:0] d, logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    cur_addr = a; cur_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 busy after accept", req_ready, 0);
    if (we) exp_m[a] = merge(exp_word(a), d, m);
  endtask

  task automatic do_write(logic [16:0] a, logic [15:0] d, logic [1:0] m);
    issue(1'b1, a, d, m);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_read(logic [16:0] a, logic [1:0] m);
    logic [15:0] e;
    int n = 0;
    issue(1'b0, a, 16'h0, m);
    e = exp_word(a);
    e = {m[1] ? e[15:8] : 8'h00, m[0] ? e[7:0] : 8'h00};
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    chk(rsp_valid, "R4 response pulse", rsp_valid, 1);
    chk(rsp_rdata == e, "R4/R6 read data", rsp_rdata, e);
    @(negedge clk);
    chk(!rsp_valid, "R4 single-cycle valid", rsp_valid, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ce1_n && !ce2 && oe_n && we_n && !dq_oe && req_ready && !rsp_valid,
        "R1 reset state", {ce1_n, ce2, oe_n, we_n, dq_oe}, 5'b10110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ce1_n && !ce2 && oe_n && we_n && !dq_oe, "R1 idle deselect",
        {ce1_n, ce2, oe_n, we_n, dq_oe}, 5'b10110);

    // directed lane cases
    do_write(17'h1ABCD, 16'h1234, 2'b11);
    do_write(17'h1ABCD, 16'hFF56, 2'b01);
    do_read (17'h1ABCD, 2'b11);  // R6 low lane only: 1256
    do_write(17'h1ABCD, 16'h9A77, 2'b10);
    do_read (17'h1ABCD, 2'b11);  // R6 high lane only: 9A56
    do_write(17'h1ABCD, 16'h0000, 2'b00);
    do_read (17'h1ABCD, 2'b11);  // R6 empty select unchanged
    do_read (17'h1ABCD, 2'b01);
    do_read (17'h1ABCD, 2'b10);
    do_read (17'h00000, 2'b11);
    // read immediately followed by write: shortest turnaround (R8)
    do_read (17'h1ABCD, 2'b11);
    do_write(17'h00001, 16'hC0DE, 2'b11);
    do_read (17'h00001, 2'b11);

    for (int i = 0; i < 8; i++) pool[i] = 17'($urandom);
    for (int i = 0; i < 300; i++) begin
      logic [16:0] a = pool[$urandom % 8];
      logic [1:0]  m = 2'($urandom);
      if ($urandom % 2) do_write(a, 16'($urandom), m);
      else              do_read(a, m);
    end
    for (int i = 0; i < 8; i++) do_read(pool[i], 2'b11);

    repeat (4) @(negedge clk);
    chk(req_ready && ce1_n && !ce2, "R1 idle after traffic", {req_ready, ce1_n, ce2}, 3'b110);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule